// File: doc/BRIEF.md
# Lockable Memory Configuration Register Bank

This block holds the control registers for ten on-chip memory regions: two program regions followed by eight data regions. Each region owns a 16-byte slot on a simple synchronous register bus. The slot holds three words: a configuration word, a lock word and a commit word. The configuration word sets a 2-bit test mode that is driven straight out to the region's memory. It also starts an initialization run and reports when that run has finished.

Writes are protected in two stages. While a region's lock bit is set, writes to its configuration word are dropped. Once the region's commit bit has been set, the lock bit itself is frozen until the next device reset. Firmware can therefore set up a region, lock it, and then commit that choice so that no later code can change it.

Reads are combinational from the current register state, so `bus_rdata` follows `bus_addr` in the same cycle. Writes take effect on the rising clock edge at which `bus_wr` is high.

Top module: `memcfg_bank`

## Requirements
- R1: After reset, every word of every region reads zero, `test_mode_o` is all zero and `init_start_o` is all zero.
- R2: Region r (program regions 0 and 1 first, then data regions 0 to 7) decodes at byte address 16*r. The configuration word is at slot offset 0x0, the lock word at 0x4 and the commit word at 0x8.
- R3: In the configuration word, bits 1:0 hold the test mode, and the test mode is read/write. A write that is accepted updates the region's `test_mode_o` slice on the next cycle. Bit 24 is the read-only done flag. Every other bit reads 0, and writes to those bits are ignored.
- R4: An accepted configuration write with bit 16 set raises that region's `init_start_o` bit for exactly the one cycle after the write. Bit 16 always reads 0. Writing 0 to bit 16 produces no pulse.
- R5: A one-cycle pulse on `init_done_i[r]` sets region r's done flag (bit 24) from the next cycle onward. A trigger clears the flag on the cycle after the write. When a trigger and a done pulse arrive in the same cycle, the trigger wins.
- R6: While lock bit 0 of a region is 1, writes to that region's configuration word are ignored. This covers both the test mode and the trigger. While the lock bit is 0, those writes are accepted.
- R7: A write to the lock word changes the lock bit only while the region's commit bit is 0.
- R8: Writing 1 to commit bit 0 sets it. Writing 0 has no effect. Only reset clears the commit bit.
- R9: The lock word and the commit word each return their stored bit in bit 0, with bits 31:1 reading 0.
- R10: Offsets that are not listed read as zero, and writes to them change no state and produce no pulse. These are slot offset 0xC, any address whose two low bits are nonzero, and any slot at or above 0xA0.
- R11: An access to one region never changes the state or outputs of another region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| init_done_i | input | 10 | Per-region initialization-complete pulse |
| test_mode_o | output | 20 | Per-region 2-bit test mode; region r uses bits 2r+1:2r |
| init_start_o | output | 10 | Per-region one-cycle initialization start pulse |

## Verification
The bench first locks a region and then sends a configuration write that carries the trigger bit. A design that gated only the mode field would still fire a start pulse. The bench also commits a region in both lock states and then tries to flip the lock bit. A design that cleared the commit bit on a 0 write, or that left the lock writable after commit, would read back the wrong lock value. Finally, the bench raises a done pulse in the same cycle as a new trigger and writes all ones to the reserved offsets, including misaligned aliases of a live word. A design with the wrong status priority, or with a partial address decode, would show a stale done flag or a corrupted neighbouring region.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

  localparam int REG_W     = 32;
  localparam int MODE_W    = 2;
  localparam int SLOT_BITS = 4;   // 16-byte slot per region
  localparam int INIT_BIT  = 16;
  localparam int STS_BIT   = 24;

  typedef enum logic [1:0] {
    WSEL_CFG    = 2'd0,
    WSEL_LOCK   = 2'd1,
    WSEL_COMMIT = 2'd2,
    WSEL_NONE   = 2'd3
  } wsel_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              init;
    logic              bit0;
  } wr_fields_t;

endpackage

// File: rtl/memcfg_decode.sv
module memcfg_decode
  import memcfg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_REG = 10
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_REG-1:0] region_sel,
  output wsel_e              wsel
);
  localparam int RIDX_W = ADDR_W - SLOT_BITS;

  logic [RIDX_W-1:0] ridx;
  logic              aligned_ok;

  assign ridx       = addr[ADDR_W-1:SLOT_BITS];
  assign wsel       = wsel_e'(addr[3:2]);
  assign aligned_ok = (addr[1:0] == 2'b00) && (addr[3:2] != WSEL_NONE);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_sel
    assign region_sel[r] = aligned_ok && (ridx == RIDX_W'(r));
  end

endmodule

// File: rtl/memcfg_region.sv
module memcfg_region
  import memcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  wsel_e             wsel,
  input  logic              wr,
  input  wr_fields_t        wf,
  input  logic              init_done,
  output logic [MODE_W-1:0] mode_o,
  output logic              start_o,
  output logic              lock_o,
  output logic              commit_o,
  output logic              sts_o,
  output logic [REG_W-1:0]  rd_word
);
  logic [MODE_W-1:0] mode_q;
  logic start_q, lock_q, commit_q, sts_q;
  logic wr_cfg, wr_lock, wr_commit, trig;

  assign wr_cfg    = wr && sel && (wsel == WSEL_CFG) && !lock_q;
  assign wr_lock   = wr && sel && (wsel == WSEL_LOCK) && !commit_q;
  assign wr_commit = wr && sel && (wsel == WSEL_COMMIT) && wf.bit0;
  assign trig      = wr_cfg && wf.init;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      start_q  <= 1'b0;
      lock_q   <= 1'b0;
      commit_q <= 1'b0;
      sts_q    <= 1'b0;
    end else begin
      if (wr_cfg)    mode_q <= wf.mode;
      start_q <= trig;
      if (trig)           sts_q <= 1'b0;
      else if (init_done) sts_q <= 1'b1;
      if (wr_lock)   lock_q   <= wf.bit0;
      if (wr_commit) commit_q <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (wsel)
      WSEL_CFG: begin
        rd_word[MODE_W-1:0] = mode_q;
        rd_word[STS_BIT]    = sts_q;
      end
      WSEL_LOCK:   rd_word[0] = lock_q;
      WSEL_COMMIT: rd_word[0] = commit_q;
      default:     rd_word = '0;
    endcase
  end

  assign mode_o   = mode_q;
  assign start_o  = start_q;
  assign lock_o   = lock_q;
  assign commit_o = commit_q;
  assign sts_o    = sts_q;

endmodule

// File: rtl/memcfg_rdmux.sv
module memcfg_rdmux
  import memcfg_pkg::*;
#(
  parameter int NUM_REG = 10
) (
  input  logic [NUM_REG-1:0]            sel,
  input  logic [NUM_REG-1:0][REG_W-1:0] words,
  output logic [REG_W-1:0]              rdata
);
  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      rdata = rdata | (words[r] & {REG_W{sel[r]}});
    end
  end
endmodule

// File: rtl/memcfg_bank.sv
module memcfg_bank
  import memcfg_pkg::*;
#(
  parameter int NUM_PROG = 2,
  parameter int NUM_DATA = 8,
  parameter int ADDR_W   = 8,
  localparam int NUM_REG = NUM_PROG + NUM_DATA
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [REG_W-1:0]          bus_wdata,
  output logic [REG_W-1:0]          bus_rdata,
  input  logic [NUM_REG-1:0]        init_done_i,
  output logic [NUM_REG*MODE_W-1:0] test_mode_o,
  output logic [NUM_REG-1:0]        init_start_o
);
  logic [NUM_REG-1:0]            region_sel;
  wsel_e                         wsel;
  wr_fields_t                    wf;
  logic [NUM_REG-1:0][REG_W-1:0] words;
  logic [NUM_REG-1:0]            lock_vec, commit_vec, sts_vec;
  logic                          unused_wdata_bits;

  assign wf.mode = bus_wdata[MODE_W-1:0];
  assign wf.init = bus_wdata[INIT_BIT];
  assign wf.bit0 = bus_wdata[0];
  assign unused_wdata_bits = ^{bus_wdata[REG_W-1:INIT_BIT+1],
                               bus_wdata[INIT_BIT-1:MODE_W]};

  memcfg_decode #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_dec (
    .addr       (bus_addr),
    .region_sel (region_sel),
    .wsel       (wsel)
  );

  for (genvar r = 0; r < NUM_REG; r++) begin : g_region
    memcfg_region u_region (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (region_sel[r]),
      .wsel      (wsel),
      .wr        (bus_wr),
      .wf        (wf),
      .init_done (init_done_i[r]),
      .mode_o    (test_mode_o[r*MODE_W +: MODE_W]),
      .start_o   (init_start_o[r]),
      .lock_o    (lock_vec[r]),
      .commit_o  (commit_vec[r]),
      .sts_o     (sts_vec[r]),
      .rd_word   (words[r])
    );
  end

  memcfg_rdmux #(.NUM_REG(NUM_REG)) u_rdmux (
    .sel   (region_sel),
    .words (words),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/memcfg_bank_chk.sv
module memcfg_bank_chk
  import memcfg_pkg::*;
#(
  parameter int NUM_REG = 10,
  parameter int ADDR_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input logic [REG_W-1:0]          bus_wdata,
  input logic [REG_W-1:0]          bus_rdata,
  input logic [NUM_REG*MODE_W-1:0] test_mode_o,
  input logic [NUM_REG-1:0]        init_start_o,
  input logic [NUM_REG-1:0]        lock_vec,
  input logic [NUM_REG-1:0]        commit_vec,
  input logic [NUM_REG-1:0]        sts_vec
);
  localparam int RIDX_W = ADDR_W - SLOT_BITS;

  logic unlisted;
  assign unlisted = (bus_addr[1:0] != 2'b00) || (bus_addr[3:2] == 2'b11) ||
                    (int'(bus_addr[ADDR_W-1:SLOT_BITS]) >= NUM_REG);

  // R10: unlisted offsets read zero
  a_r10_unlisted_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unlisted |-> bus_rdata == '0);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_chk
    logic cfg_hit;
    assign cfg_hit = bus_wr && (bus_addr == ADDR_W'(r << SLOT_BITS));

    // R4: a start pulse only follows an accepted trigger write
    a_r4_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      init_start_o[r] |-> $past(cfg_hit && bus_wdata[INIT_BIT] && !lock_vec[r]));

    // R3: accepted config write updates the mode output next cycle
    a_r3_mode_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hit && !lock_vec[r]) |=>
        test_mode_o[r*MODE_W +: MODE_W] == $past(bus_wdata[MODE_W-1:0]));

    // R6: a locked region keeps its mode
    a_r6_locked_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[r] |=> $stable(test_mode_o[r*MODE_W +: MODE_W]));

    // R5: the cycle a start pulse is out, the done flag is clear
    a_r5_trigger_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
      init_start_o[r] |-> !sts_vec[r]);

    // R7: lock bit is frozen once committed
    a_r7_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vec[r] |=> $stable(lock_vec[r]));

    // R8: commit bit never falls outside reset
    a_r8_commit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vec[r] |=> commit_vec[r]);
  end

endmodule

bind memcfg_bank memcfg_bank_chk #(.NUM_REG(NUM_REG), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .test_mode_o  (test_mode_o),
  .init_start_o (init_start_o),
  .lock_vec     (lock_vec),
  .commit_vec   (commit_vec),
  .sts_vec      (sts_vec)
);

// File: tb/memcfg_bank_tb.sv
module memcfg_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NR-1:0]   init_done_i = '0;
  logic [2*NR-1:0] test_mode_o;
  logic [NR-1:0]   init_start_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memcfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_done_i(init_done_i),
    .test_mode_o(test_mode_o), .init_start_o(init_start_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns at the negedge after the capturing edge
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] cfg_a(int r); return 8'(r * 16);     endfunction
  function automatic logic [7:0] lck_a(int r); return 8'(r * 16 + 4); endfunction
  function automatic logic [7:0] cmt_a(int r); return 8'(r * 16 + 8); endfunction

  task automatic t_reset();
    logic [31:0] d;
    bit all_zero = 1;
    for (int r = 0; r < NR; r++) begin
      bus_read(cfg_a(r), d); if (d != 0) all_zero = 0;
      bus_read(lck_a(r), d); if (d != 0) all_zero = 0;
      bus_read(cmt_a(r), d); if (d != 0) all_zero = 0;
    end
    chk("R1", "all words zero after reset", 32'(all_zero), 32'd1);
    chk("R1", "test_mode_o after reset", 32'(test_mode_o), 32'd0);
    chk("R1", "init_start_o after reset", 32'(init_start_o), 32'd0);
  endtask

  task automatic t_mode_map();
    logic [31:0] d;
    for (int r = 0; r < NR; r++)
      bus_write(cfg_a(r), 32'hA5A0_A5A0 | 32'((r % 3) + 1));
    for (int r = 0; r < NR; r++) begin
      bus_read(cfg_a(r), d);
      chk("R2", $sformatf("cfg readback region %0d (R3 masking, R11)", r), d, 32'((r % 3) + 1));
      chk("R3", $sformatf("test_mode_o slice region %0d", r),
          32'(test_mode_o[r*2 +: 2]), 32'((r % 3) + 1));
    end
  endtask

  task automatic t_init();
    logic [31:0] d;
    bus_write(cfg_a(3), 32'h0001_0001);
    chk("R4", "start pulse after trigger", 32'(init_start_o), 32'h8);
    bus_read(cfg_a(3), d);
    chk("R4", "trigger bit reads 0", d, 32'h1);
    @(negedge clk);
    chk("R4", "pulse lasts one cycle", 32'(init_start_o), 32'h0);
    bus_write(cfg_a(3), 32'h0000_0001);
    chk("R4", "no pulse when bit16 is 0", 32'(init_start_o), 32'h0);
    init_done_i[3] = 1'b1;
    @(negedge clk);
    init_done_i[3] = 1'b0;
    bus_read(cfg_a(3), d);
    chk("R5", "done flag set after done pulse", d, 32'h0100_0001);
    bus_read(cfg_a(4), d);
    chk("R11", "neighbour done flag untouched", d, 32'h2);
    bus_write(cfg_a(3), 32'h0001_0001);
    bus_read(cfg_a(3), d);
    chk("R5", "retrigger clears done flag", d, 32'h1);
    init_done_i[3] = 1'b1;
    bus_write(cfg_a(3), 32'h0001_0001);
    init_done_i[3] = 1'b0;
    bus_read(cfg_a(3), d);
    chk("R5", "trigger beats same-cycle done", d, 32'h1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_write(cfg_a(5), 32'h2);
    bus_write(lck_a(5), 32'hFFFF_FFFF);
    bus_read(lck_a(5), d);
    chk("R9", "lock word reads bit0 only", d, 32'h1);
    bus_write(cfg_a(5), 32'h0001_0001);
    chk("R6", "locked trigger gives no pulse", 32'(init_start_o), 32'h0);
    bus_read(cfg_a(5), d);
    chk("R6", "locked mode unchanged", d, 32'h2);
    chk("R6", "locked mode output unchanged", 32'(test_mode_o[11:10]), 32'h2);
    bus_write(lck_a(5), 32'h0);
    bus_write(cfg_a(5), 32'h1);
    bus_read(cfg_a(5), d);
    chk("R6", "unlocked write accepted", d, 32'h1);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    logic [7:0] bad [5] = '{8'h0C, 8'hA0, 8'hF8, 8'h01, 8'h16};
    bit quiet = 1;
    for (int i = 0; i < 5; i++) begin
      bus_write(bad[i], 32'hFFFF_FFFF);
      if (init_start_o != 0) quiet = 0;
    end
    chk("R10", "no pulse from unlisted writes", 32'(quiet), 32'd1);
    for (int i = 0; i < 5; i++) begin
      bus_read(bad[i], d);
      chk("R10", $sformatf("unlisted 0x%02h reads zero", bad[i]), d, 32'h0);
    end
    bus_read(cfg_a(0), d);
    chk("R10", "region 0 cfg intact", d, 32'h1);
    bus_read(lck_a(1), d);
    chk("R10", "region 1 lock intact", d, 32'h0);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    bus_write(lck_a(9), 32'h1);
    bus_write(cmt_a(9), 32'h0);
    bus_read(cmt_a(9), d);
    chk("R8", "commit not set by 0", d, 32'h0);
    bus_write(cmt_a(9), 32'hFFFF_FFFF);
    bus_read(cmt_a(9), d);
    chk("R9", "commit word reads bit0 only", d, 32'h1);
    bus_write(lck_a(9), 32'h0);
    bus_read(lck_a(9), d);
    chk("R7", "committed lock stays 1", d, 32'h1);
    bus_write(cmt_a(9), 32'h0);
    bus_read(cmt_a(9), d);
    chk("R8", "commit not cleared by 0", d, 32'h1);
    bus_write(cfg_a(9), 32'h3);
    bus_read(cfg_a(9), d);
    chk("R6", "committed lock still blocks cfg", d, 32'h1);
    bus_write(cmt_a(0), 32'h1);
    bus_write(lck_a(0), 32'h1);
    bus_read(lck_a(0), d);
    chk("R7", "committed unlocked lock stays 0", d, 32'h0);
    bus_write(cfg_a(0), 32'h2);
    bus_read(cfg_a(0), d);
    chk("R7", "cfg still writable when committed unlocked", d, 32'h2);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    do_reset();
    bus_read(cmt_a(9), d);
    chk("R8", "reset clears commit", d, 32'h0);
    bus_read(lck_a(9), d);
    chk("R1", "reset clears lock", d, 32'h0);
    chk("R1", "reset clears mode outputs", 32'(test_mode_o), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_mode_map();
    t_init();
    t_lock();
    t_reserved();
    t_commit();
    t_reset_again();
    summary();
    $finish;
  end

endmodule